// File: doc/BRIEF.md
# Address-Protected SEC-DED ECC Codec

This block generates and checks an error-correcting code for a 64-bit memory word. The eight check bits cover the data word and the word-aligned part of its address (bits 31 down to 3). If a read comes back from the wrong row, the mismatch between the stored check bits and the address used for the read shows up as a nonzero syndrome. A readout that is stuck at all zeros or all ones does the same. Neither case can pass as clean data.

The encoder is purely combinational. A memory controller drives the write data and write address into it and stores the resulting check byte beside the word. On a read, the controller presents the stored word, the stored check byte and the read address together with a valid strobe. One cycle later the decoder returns:
- the repaired data and check byte,
- a single-bit-corrected flag,
- a multi-bit-error flag,
- the syndrome.

A bypass input hands the raw word and raw check byte straight through. This gives test software an unfiltered view of every stored bit.

The code is built from H-matrix columns of odd weight three or more, enumerated in ascending numeric order. Data bits take the first 64 columns and address bits take the next 29. Each check bit covers its own position with a weight-one column. The partial check values from the two data halves and from the address are computed separately and then XORed together.

Top module: `addr_secded_codec`

## Requirements
- R1: `enc_chk` is the XOR of column c(i) for every set data bit i and of column c(64 + j - 3) for every set address bit j (3 to 31). Column c(k) is the k-th 8-bit value, counting from zero, in ascending order among the values with an odd number of ones and at least three ones. Bit 0 is the least significant bit of every field.
- R2: The syndrome is the stored check byte XOR the check value recomputed from the stored data and the read address. When it is zero, the data and check bits pass unchanged and both flags stay low.
- R3: A syndrome equal to data column c(i) inverts data bit i, raises `out_sbc` and reports that syndrome.
- R4: A syndrome with exactly one bit set repairs that check bit in `out_chk`, leaves the data unchanged and raises `out_sbc`.
- R5: A syndrome equal to an address column raises `out_mbe` with `out_sbc` low, and leaves the data and check bits unrepaired.
- R6: A nonzero syndrome of even weight, or an odd-weight syndrome that matches no column, raises `out_mbe` and leaves the data and check bits unrepaired. `out_sbc` and `out_mbe` are never high together.
- R7: A word and check byte read back as all zeros or as all ones, at an address that is not specially chosen, produces a nonzero syndrome and raises one of the two flags.
- R8: With `dec_bypass` high, `out_data` and `out_chk` equal the raw inputs, both flags are low and `out_syndrome` is zero.
- R9: `out_valid` is high exactly in the cycle after a cycle with `dec_valid_in` high. While no request arrives, the other outputs hold their values. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_data | input | 64 | Data word to encode |
| enc_addr | input | 29 | Address bits 31:3 of the word to encode |
| enc_chk | output | 8 | Check byte for the encoder inputs |
| dec_valid_in | input | 1 | Read request strobe |
| dec_bypass | input | 1 | Pass raw data and check bits through unfiltered |
| dec_data | input | 64 | Stored data word |
| dec_chk | input | 8 | Stored check byte |
| dec_addr | input | 29 | Address bits 31:3 used for the read |
| out_valid | output | 1 | Decoder result valid |
| out_data | output | 64 | Corrected (or raw in bypass) data |
| out_chk | output | 8 | Corrected (or raw in bypass) check byte |
| out_sbc | output | 1 | Single-bit error corrected |
| out_mbe | output | 1 | Uncorrectable or address error |
| out_syndrome | output | 8 | Registered syndrome |

## Verification
The assertions check on every cycle that:
- the two flags are never high together;
- a zero syndrome never raises a flag;
- an even-weight syndrome always raises the multi-bit flag;
- a decode changes at most one data bit;
- an address-column hit leaves the data untouched;
- bypass copies the raw inputs;
- the valid strobe trails the request by exactly one cycle.

The bench scenarios are needed to show that the column order and the fold of the address into the code are correct:
- flipped data bits and check bits are repaired in the right position;
- a read at a neighbouring row is rejected;
- all-zero and all-one readouts are caught;
- outputs hold while the block is idle.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int CHK_W    = 8;
  localparam int DATA_W   = 64;
  localparam int ADDR_W   = 32;
  localparam int ADDR_LSB = 3;
  localparam int ADDR_COLS = ADDR_W - ADDR_LSB;
  localparam int NUM_COLS  = DATA_W + ADDR_COLS;

  typedef logic [CHK_W-1:0] chk_t;

  typedef enum logic [2:0] {
    SYN_CLEAN = 3'd0,
    SYN_DATA  = 3'd1,
    SYN_CHECK = 3'd2,
    SYN_ADDR  = 3'd3,
    SYN_MULTI = 3'd4
  } syn_kind_e;

  // Column k of the H matrix: the k-th odd-weight value (weight >= 3),
  // counted in ascending numeric order from zero.
  function automatic chk_t hcol(input int k);
    chk_t res;
    int   seen;
    res  = '0;
    seen = 0;
    for (int v = 0; v < (1 << CHK_W); v++) begin
      chk_t cand;
      int   wt;
      cand = chk_t'(v);
      wt   = $countones(cand);
      if ((wt % 2 == 1) && (wt >= 3)) begin
        if (seen == k) res = cand;
        seen++;
      end
    end
    return res;
  endfunction

  function automatic logic odd_weight(input chk_t s);
    return ($countones(s) % 2) == 1;
  endfunction

endpackage

// File: rtl/secded_seg_fold.sv
module secded_seg_fold
  import secded_pkg::*;
#(
  parameter int W    = 32,
  parameter int BASE = 0
) (
  input  logic [W-1:0] bits,
  output chk_t         part
);

  // XOR of the H-matrix columns selected by the set input bits
  always_comb begin
    part = '0;
    for (int i = 0; i < W; i++) begin
      if (bits[i]) part = part ^ hcol(BASE + i);
    end
  end

endmodule

// File: rtl/secded_chk_gen.sv
module secded_chk_gen
  import secded_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_COLS,
  parameter int NSEG  = 2
) (
  input  logic [DW-1:0] data,
  input  logic [AW-1:0] addr_hi,
  output chk_t          chk
);

  localparam int SEG_W = DW / NSEG;

  chk_t part [NSEG+1];

  // Independent data segments, each folded on its own
  for (genvar s = 0; s < NSEG; s++) begin : g_dseg
    secded_seg_fold #(
      .W   (SEG_W),
      .BASE(s * SEG_W)
    ) u_fold (
      .bits(data[s*SEG_W +: SEG_W]),
      .part(part[s])
    );
  end

  // Address contribution uses the columns following the data columns
  secded_seg_fold #(
    .W   (AW),
    .BASE(DW)
  ) u_afold (
    .bits(addr_hi),
    .part(part[NSEG])
  );

  always_comb begin
    chk = '0;
    for (int s = 0; s <= NSEG; s++) chk = chk ^ part[s];
  end

endmodule

// File: rtl/secded_syn_sort.sv
module secded_syn_sort
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_COLS
) (
  input  chk_t          syn,
  output syn_kind_e     kind,
  output logic [DW-1:0] data_flip,
  output chk_t          chk_flip,
  output logic          hit_data,
  output logic          hit_chk,
  output logic          hit_addr
);

  always_comb begin
    hit_data  = 1'b0;
    hit_addr  = 1'b0;
    data_flip = '0;
    for (int i = 0; i < DW; i++) begin
      if (syn == hcol(i)) begin
        hit_data     = 1'b1;
        data_flip[i] = 1'b1;
      end
    end
    for (int j = 0; j < AW; j++) begin
      if (syn == hcol(DW + j)) hit_addr = 1'b1;
    end
    hit_chk  = ($countones(syn) == 1);
    chk_flip = hit_chk ? syn : '0;

    if (syn == '0)     kind = SYN_CLEAN;
    else if (hit_data) kind = SYN_DATA;
    else if (hit_chk)  kind = SYN_CHECK;
    else if (hit_addr) kind = SYN_ADDR;
    else               kind = SYN_MULTI;

    AST_ONE_COLUMN_HIT: assert ($onehot0({hit_data, hit_chk, hit_addr})); // R6
  end

endmodule

// File: rtl/addr_secded_codec.sv
module addr_secded_codec
  import secded_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int ALSB = ADDR_LSB,
  parameter int NSEG = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DW-1:0]       enc_data,
  input  logic [AW-1:ALSB]    enc_addr,
  output logic [CHK_W-1:0]    enc_chk,
  input  logic                dec_valid_in,
  input  logic                dec_bypass,
  input  logic [DW-1:0]       dec_data,
  input  logic [CHK_W-1:0]    dec_chk,
  input  logic [AW-1:ALSB]    dec_addr,
  output logic                out_valid,
  output logic [DW-1:0]       out_data,
  output logic [CHK_W-1:0]    out_chk,
  output logic                out_sbc,
  output logic                out_mbe,
  output logic [CHK_W-1:0]    out_syndrome
);

  localparam int ACOLS = AW - ALSB;

  // ---------------- encoder ----------------
  secded_chk_gen #(.DW(DW), .AW(ACOLS), .NSEG(NSEG)) u_enc (
    .data   (enc_data),
    .addr_hi(enc_addr),
    .chk    (enc_chk)
  );

  // ---------------- decoder ----------------
  chk_t          recomputed;
  chk_t          syn;
  syn_kind_e     kind;
  logic [DW-1:0] data_flip;
  chk_t          chk_flip;
  logic          hit_data, hit_chk, hit_addr;

  secded_chk_gen #(.DW(DW), .AW(ACOLS), .NSEG(NSEG)) u_dec_gen (
    .data   (dec_data),
    .addr_hi(dec_addr),
    .chk    (recomputed)
  );

  assign syn = dec_chk ^ recomputed;

  secded_syn_sort #(.DW(DW), .AW(ACOLS)) u_sort (
    .syn      (syn),
    .kind     (kind),
    .data_flip(data_flip),
    .chk_flip (chk_flip),
    .hit_data (hit_data),
    .hit_chk  (hit_chk),
    .hit_addr (hit_addr)
  );

  // Named events for the assertions
  logic ev_correctable, ev_uncorrectable, ev_addr_fault;
  assign ev_correctable   = (kind == SYN_DATA) || (kind == SYN_CHECK);
  assign ev_uncorrectable = (kind == SYN_ADDR) || (kind == SYN_MULTI);
  assign ev_addr_fault    = (kind == SYN_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_chk      <= '0;
      out_sbc      <= 1'b0;
      out_mbe      <= 1'b0;
      out_syndrome <= '0;
    end else begin
      out_valid <= dec_valid_in;
      if (dec_valid_in) begin
        if (dec_bypass) begin
          out_data     <= dec_data;
          out_chk      <= dec_chk;
          out_sbc      <= 1'b0;
          out_mbe      <= 1'b0;
          out_syndrome <= '0;
        end else begin
          out_data     <= dec_data ^ data_flip;
          out_chk      <= dec_chk ^ chk_flip;
          out_sbc      <= ev_correctable;
          out_mbe      <= ev_uncorrectable;
          out_syndrome <= syn;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_sbc && out_mbe)); // R6

  AST_ZERO_SYN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_syndrome == '0) |-> (!out_sbc && !out_mbe)); // R2

  AST_EVEN_SYN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_syndrome != '0 && !odd_weight(out_syndrome)) |-> out_mbe); // R6

  AST_AT_MOST_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_in && !dec_bypass) |=> ($countones(out_data ^ $past(dec_data)) <= 1)); // R3

  AST_ADDR_FAULT_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_in && !dec_bypass && ev_addr_fault) |=>
      (out_mbe && !out_sbc && out_data == $past(dec_data))); // R5

  AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_in && dec_bypass) |=>
      (out_data == $past(dec_data) && out_chk == $past(dec_chk) &&
       !out_sbc && !out_mbe && out_syndrome == '0)); // R8

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_in |=> out_valid); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_in |=> (!out_valid && $stable(out_data) && $stable(out_chk))); // R9

endmodule

// File: tb/test_addr_secded_codec.sv
module test_addr_secded_codec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] enc_data = '0;
  logic [31:3] enc_addr = '0;
  logic [7:0]  enc_chk;
  logic        dec_valid_in = 1'b0;
  logic        dec_bypass = 1'b0;
  logic [63:0] dec_data = '0;
  logic [7:0]  dec_chk = '0;
  logic [31:3] dec_addr = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [7:0]  out_chk;
  logic        out_sbc, out_mbe;
  logic [7:0]  out_syndrome;

  always #2 clk = ~clk; // 250 MHz

  addr_secded_codec i_addr_secded_codec (
    .clk(clk), .rst_n(rst_n),
    .enc_data(enc_data), .enc_addr(enc_addr), .enc_chk(enc_chk),
    .dec_valid_in(dec_valid_in), .dec_bypass(dec_bypass),
    .dec_data(dec_data), .dec_chk(dec_chk), .dec_addr(dec_addr),
    .out_valid(out_valid), .out_data(out_data), .out_chk(out_chk),
    .out_sbc(out_sbc), .out_mbe(out_mbe), .out_syndrome(out_syndrome)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] cols[$];

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Column table built by weight counting with shifts
  function automatic int bit_weight(input int v);
    int w = 0;
    int x = v;
    while (x != 0) begin
      w += x & 1;
      x = x >> 1;
    end
    return w;
  endfunction

  function automatic logic [7:0] ref_enc(input logic [63:0] d, input logic [31:0] a);
    logic [7:0] acc = 8'h00;
    for (int i = 0; i < 64; i++) if (d[i]) acc ^= cols[i];
    for (int j = 3; j < 32; j++) if (a[j]) acc ^= cols[64 + j - 3];
    return acc;
  endfunction

  // Behavioural decoder model
  task automatic ref_dec(input logic [63:0] d, input logic [7:0] c, input logic [31:0] a,
                         input logic byp,
                         output logic [63:0] ed, output logic [7:0] ec,
                         output logic es, output logic em, output logic [7:0] esyn);
    logic [7:0] s;
    int hit;
    ed = d; ec = c; es = 0; em = 0; esyn = 0;
    if (byp) return;
    s = c ^ ref_enc(d, a);
    esyn = s;
    if (s == 0) return;
    hit = -1;
    foreach (cols[k]) if (cols[k] == s) hit = k;
    if (hit >= 0 && hit < 64) begin
      ed[hit] = ~d[hit]; es = 1;
    end else if (bit_weight(int'(s)) == 1) begin
      ec = c ^ s; es = 1;
    end else begin
      em = 1;
    end
  endtask

  // Assumes the caller is at a negative edge
  task automatic dec(input string tag, input logic [63:0] d, input logic [7:0] c,
                     input logic [31:0] a, input logic byp);
    logic [63:0] ed; logic [7:0] ec; logic es, em; logic [7:0] esyn;
    ref_dec(d, c, a, byp, ed, ec, es, em, esyn);
    dec_data = d; dec_chk = c; dec_addr = a[31:3]; dec_bypass = byp; dec_valid_in = 1'b1;
    @(negedge clk);
    cmp({tag, " R9 valid"}, 64'(out_valid), 64'd1);
    cmp({tag, " data"}, out_data, ed);
    cmp({tag, " chk"}, 64'(out_chk), 64'(ec));
    cmp({tag, " sbc"}, 64'(out_sbc), 64'(es));
    cmp({tag, " mbe"}, 64'(out_mbe), 64'(em));
    cmp({tag, " syndrome"}, 64'(out_syndrome), 64'(esyn));
  endtask

  task automatic enc_check(input string tag, input logic [63:0] d, input logic [31:0] a);
    enc_data = d; enc_addr = a[31:3];
    #1;
    cmp(tag, 64'(enc_chk), 64'(ref_enc(d, a)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [31:0] a;
    logic [7:0]  c;
    for (int v = 0; v < 256; v++)
      if (bit_weight(v) % 2 == 1 && bit_weight(v) > 1) cols.push_back(8'(v));

    repeat (3) @(negedge clk);
    cmp("R9 reset valid", 64'(out_valid), 64'd0);
    cmp("R9 reset data", out_data, 64'd0);
    cmp("R9 reset flags", 64'({out_sbc, out_mbe}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 encoder
    enc_check("R1 zero", 64'd0, 32'd0);
    enc_check("R1 bit0", 64'd1, 32'd0);
    enc_check("R1 bit63", 64'h8000_0000_0000_0000, 32'd0);
    enc_check("R1 addr3", 64'd0, 32'h8);
    enc_check("R1 addr31", 64'd0, 32'h8000_0000);
    cmp("R1 column0", 64'(cols[0]), 64'h07);
    for (int n = 0; n < 8; n++) enc_check("R1 random", {$urandom, $urandom}, $urandom);

    // R2 clean reads
    for (int n = 0; n < 10; n++) begin
      d = {$urandom, $urandom}; a = $urandom;
      dec("R2 clean", d, ref_enc(d, a), a, 1'b0);
    end

    // R3 single data bit errors
    foreach (cols[k]) if (k < 64 && (k % 7 == 0 || k == 31 || k == 32 || k == 63)) begin
      d = {$urandom, $urandom}; a = $urandom;
      dec("R3 data flip", d ^ (64'd1 << k), ref_enc(d, a), a, 1'b0);
      cmp("R3 repaired", out_data, d);
    end

    // R4 check bit errors
    for (int b = 0; b < 8; b++) begin
      d = {$urandom, $urandom}; a = $urandom; c = ref_enc(d, a);
      dec("R4 chk flip", d, c ^ (8'd1 << b), a, 1'b0);
      cmp("R4 chk repaired", 64'(out_chk), 64'(c));
    end

    // R5 wrong row
    foreach (cols[k]) if (k >= 64 && (k == 64 || k == 78 || k == 92)) begin
      d = {$urandom, $urandom}; a = $urandom;
      dec("R5 addr mismatch", d, ref_enc(d, a), a ^ (32'd1 << (k - 61)), 1'b0);
      cmp("R5 mbe", 64'({out_sbc, out_mbe}), 64'd1);
    end

    // R6 double errors
    d = {$urandom, $urandom}; a = $urandom;
    dec("R6 two data", d ^ 64'h0000_0001_0000_0100, ref_enc(d, a), a, 1'b0);
    cmp("R6 mbe", 64'(out_mbe), 64'd1);
    dec("R6 data+chk", d ^ 64'h10, ref_enc(d, a) ^ 8'h80, a, 1'b0);
    cmp("R6 mbe2", 64'(out_mbe), 64'd1);

    // R7 stuck readouts
    dec("R7 all zero", 64'd0, 8'h00, 32'h0000_1000, 1'b0);
    cmp("R7 zero flagged", 64'(out_sbc | out_mbe), 64'd1);
    dec("R7 all one", {64{1'b1}}, 8'hFF, 32'h0024_6E08, 1'b0);
    cmp("R7 one flagged", 64'(out_syndrome != 0), 64'd1);

    // R8 bypass with corrupt word
    d = {$urandom, $urandom};
    dec("R8 bypass", d, 8'h5A, $urandom, 1'b1);

    // R9 idle hold
    d = out_data;
    dec_valid_in = 1'b0;
    @(negedge clk);
    cmp("R9 idle valid", 64'(out_valid), 64'd0);
    cmp("R9 idle hold", out_data, d);
    @(negedge clk);
    cmp("R9 idle hold2", out_data, d);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule